// File: doc/BRIEF.md
# Programmable 8-bit Timer/Event Counter

This block is an 8-bit up-counter that sits on a small register bus. It can run as a timer or as an event counter. As a timer it advances on an internal instruction-cycle tick, which comes once every four system clocks. As an event counter it advances on a chosen edge of an external input. That input first passes through a two-flop synchroniser and an edge detector, so each counted edge gives exactly one single-cycle pulse.

A divider with a 3-bit rate field can be placed between the count source and the counter. It divides by 2, 4 and so on up to 256. The divider can instead be handed to a neighbouring user. In that case every tick reaches the counter directly, and the neighbour may reset the divider through a dedicated clear input. When the counter steps from FFh to 00h, a sticky overflow flag is set. The interrupt output is that flag gated by a local enable and a global enable.

The bus is a single-cycle write strobe with a 2-bit address. The read data depend combinationally on the address.

Top module: `tmr8_unit`

## Requirements
- R1: Address 0 reads the current count. A write to address 0 loads the written byte into the count on that clock edge, and it takes priority over an increment in the same cycle.
- R2: With the source bit (address 1, bit 5) at 0, the counter source is an internal tick that occurs exactly once in every four system clocks.
- R3: With the source bit at 1, edges of `ext_in` are counted after a two-flop synchroniser. The edge bit (address 1, bit 4) selects the edge: 0 counts rising edges and 1 counts falling edges. The edge bit has no effect in internal mode.
- R4: With the assignment bit (address 1, bit 3) at 1, every source tick increments the count. With it at 0, source ticks pass through the divider.
- R5: The rate field (address 1, bits 2:0) sets the divide ratio to 2^(rate+1): 000 gives 1:2 and 111 gives 1:256.
- R6: While the assignment bit is 0, a write to address 0 clears the divider, so the next increment needs a full ratio of ticks.
- R7: `shared_clr` clears the divider only while the assignment bit is 1. While the bit is 0, `shared_clr` is ignored.
- R8: The overflow flag (address 2, bit 0) is set only when an increment takes the count from FFh to 00h, never by a load. A write to address 2 with bit 0 at 0 clears the flag, and a write with bit 0 at 1 leaves it unchanged. If an overflow and a clear happen in the same cycle, the overflow wins.
- R9: `irq` is high exactly when the flag, the local enable (address 2, bit 1) and the global enable (address 2, bit 2) are all 1.
- R10: After reset the count is 00h, address 1 reads 08h (assignment bit set, all else 0), and address 2 reads 00h. Unused read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Register address: 0 count, 1 config, 2 control/flag |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| ext_in | input | 1 | External event input, asynchronous |
| shared_clr | input | 1 | Divider clear from the neighbouring user |
| irq | output | 1 | Masked overflow interrupt |

## Verification
The bench sweeps all eight rates in timer mode over windows that are whole multiples of four times the ratio. A divider off by one, or an internal tick with the wrong spacing, would show up as an increment count that is too high or too low. Single external transitions are driven in each edge mode, so a swapped polarity would count the wrong half-pulse. The divider is left part-way full before a count write and before a neighbour clear. A design that failed to clear on the write, or that obeyed the neighbour clear while owning the divider, would then produce one increment too many or too few. Overflow is provoked by loading FFh, and a direct FFh-to-00h load is also driven. A flag set by a load, a flag set by a write of 1, or an interrupt ignoring either enable would show up in the flag and `irq` readings.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
    localparam int CNT_W   = 8;
    localparam int RATE_W  = 3;
    localparam int PRE_W   = 2 ** RATE_W;
    localparam int TICK_DIV = 4;
    localparam int ADDR_W  = 2;

    localparam logic [ADDR_W-1:0] A_COUNT = 2'd0;
    localparam logic [ADDR_W-1:0] A_CFG   = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL  = 2'd2;

    typedef struct packed {
        logic              use_ext;
        logic              fall_edge;
        logic              bypass;
        logic [RATE_W-1:0] rate;
    } tmr_cfg_t;

    typedef struct packed {
        logic gie;
        logic ie;
    } tmr_en_t;

    localparam tmr_cfg_t CFG_RESET = '{use_ext: 1'b0, fall_edge: 1'b0,
                                       bypass: 1'b1, rate: '0};

    function automatic logic [PRE_W-1:0] div_last(input logic [RATE_W-1:0] r);
        logic [PRE_W:0] ratio;
        ratio = (PRE_W+1)'(2) << r;
        return PRE_W'(ratio - 1'b1);
    endfunction
endpackage

// File: rtl/tmr8_tick_src.sv
module tmr8_tick_src
    import tmr8_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ext_in,
    input  logic use_ext,
    input  logic fall_edge,
    output logic src_tick
);
    localparam int PH_W = $clog2(TICK_DIV);

    logic [PH_W-1:0] phase_q;
    logic            int_tick;
    logic [2:0]      sync_q;
    logic            rise_p, fall_p, ext_tick;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= '0;
        else     phase_q <= phase_q + 1'b1;
    end

    assign int_tick = (phase_q == PH_W'(TICK_DIV-1));

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[1:0], ext_in};
    end

    assign rise_p   =  sync_q[1] & ~sync_q[2];
    assign fall_p   = ~sync_q[1] &  sync_q[2];
    assign ext_tick = fall_edge ? fall_p : rise_p;
    assign src_tick = use_ext ? ext_tick : int_tick;

    // R2: internal ticks never come back to back
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        int_tick |=> !int_tick);

    // R3: an external edge yields a single-cycle pulse
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        ext_tick |=> !ext_tick);
endmodule

// File: rtl/tmr8_prescale.sv
module tmr8_prescale
    import tmr8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              src_tick,
    input  logic              bypass,
    input  logic [RATE_W-1:0] rate,
    input  logic              own_clr,
    input  logic              shared_clr,
    output logic              inc
);
    logic [PRE_W-1:0] div_q;
    logic             clr;
    logic             wrap;

    assign clr  = bypass ? shared_clr : own_clr;
    assign wrap = (div_q == div_last(rate));

    always_ff @(posedge clk) begin
        if (rst || clr)    div_q <= '0;
        else if (src_tick) div_q <= wrap ? '0 : div_q + 1'b1;
    end

    assign inc = bypass ? src_tick : (src_tick && wrap && !own_clr);

    // R4: no increment without a source tick
    a_r4_inc_needs_tick: assert property (@(posedge clk) disable iff (rst)
        inc |-> src_tick);

    // R7: a neighbour clear while the divider is owned leaves it running
    a_r7_shared_ignored: assert property (@(posedge clk) disable iff (rst)
        (!bypass && !own_clr && !src_tick) |=> $stable(div_q));
endmodule

// File: rtl/tmr8_core.sv
module tmr8_core
    import tmr8_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             ovf_flag
);
    logic wrap_hit;

    assign wrap_hit = inc && !load && (count == {CNT_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (load) count <= load_val;
        else if (inc)  count <= count + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)           ovf_flag <= 1'b0;
        else if (wrap_hit) ovf_flag <= 1'b1;
        else if (flag_clr) ovf_flag <= 1'b0;
    end

    // R1: a load lands on the next edge
    a_r1_load: assert property (@(posedge clk) disable iff (rst)
        load |=> count == $past(load_val));

    // R1: without a load the count holds or steps by one
    a_r1_step: assert property (@(posedge clk) disable iff (rst)
        !load |=> (count == $past(count) || count == CNT_W'($past(count) + 1'b1)));

    // R8: the flag rises only on a wrap from all-ones to zero
    a_r8_flag_on_wrap: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> (count == '0 && $past(count) == {CNT_W{1'b1}}));
endmodule

// File: rtl/tmr8_unit.sv
module tmr8_unit
    import tmr8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              ext_in,
    input  logic              shared_clr,
    output logic              irq
);
    tmr_cfg_t         cfg_q;
    tmr_en_t          en_q;
    logic             wr_cnt, wr_cfg, wr_ctrl;
    logic             src_tick, inc;
    logic [CNT_W-1:0] count;
    logic             ovf_flag;

    assign wr_cnt  = bus_we && (bus_addr == A_COUNT);
    assign wr_cfg  = bus_we && (bus_addr == A_CFG);
    assign wr_ctrl = bus_we && (bus_addr == A_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
            en_q  <= '0;
        end else begin
            if (wr_cfg)  cfg_q <= tmr_cfg_t'(bus_wdata[$bits(tmr_cfg_t)-1:0]);
            if (wr_ctrl) en_q  <= tmr_en_t'(bus_wdata[2:1]);
        end
    end

    tmr8_tick_src u_src (
        .clk       (clk),
        .rst       (rst),
        .ext_in    (ext_in),
        .use_ext   (cfg_q.use_ext),
        .fall_edge (cfg_q.fall_edge),
        .src_tick  (src_tick)
    );

    tmr8_prescale u_pre (
        .clk        (clk),
        .rst        (rst),
        .src_tick   (src_tick),
        .bypass     (cfg_q.bypass),
        .rate       (cfg_q.rate),
        .own_clr    (wr_cnt),
        .shared_clr (shared_clr),
        .inc        (inc)
    );

    tmr8_core u_core (
        .clk      (clk),
        .rst      (rst),
        .inc      (inc),
        .load     (wr_cnt),
        .load_val (bus_wdata),
        .flag_clr (wr_ctrl && !bus_wdata[0]),
        .count    (count),
        .ovf_flag (ovf_flag)
    );

    always_comb begin
        unique case (bus_addr)
            A_COUNT: bus_rdata = count;
            A_CFG:   bus_rdata = CNT_W'(cfg_q);
            A_CTRL:  bus_rdata = CNT_W'({en_q, ovf_flag});
            default: bus_rdata = '0;
        endcase
    end

    assign irq = ovf_flag && en_q.ie && en_q.gie;

    // R9: interrupt never fires without the flag
    a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        irq |-> ovf_flag);
endmodule

// File: tb/tb_tmr8_unit.sv
module tb_tmr8_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       ext_in = 1'b0;
    logic       shared_clr = 1'b0;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tmr8_unit dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_in(ext_in),
        .shared_clr(shared_clr), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ext_to(input logic v);
        @(negedge clk);
        ext_in = v;
        idle(5);
    endtask

    task automatic pulse();
        ext_to(1'b1);
        ext_to(1'b0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            finish_run();
        end
    end

    initial begin
        int v;
        idle(3);
        // R10: reset state
        rd(2'd0, v); check("R10 count", v, 0);
        rd(2'd1, v); check("R10 cfg", v, 8'h08);
        rd(2'd2, v); check("R10 ctrl", v, 0);
        check("R10 irq", irq, 0);
        @(negedge clk); rst = 1'b0;

        // R2/R4: bypass, internal -> one increment per four clocks
        wr(2'd1, 8'h08);
        wr(2'd0, 8'h00);
        idle(400);
        rd(2'd0, v); check("R2 R4 internal bypass", v, 100);

        // R3: edge bit ignored in internal mode
        wr(2'd1, 8'h18);
        wr(2'd0, 8'h00);
        idle(400);
        rd(2'd0, v); check("R3 edge ignored internal", v, 100);

        // R5/R6: every rate, two increments over 8*ratio clocks
        for (int r = 0; r < 8; r++) begin
            wr(2'd1, 8'(r));
            wr(2'd0, 8'h00);
            idle(4 * (2 << r) * 2);
            rd(2'd0, v); check($sformatf("R5 rate %0d", r), v, 2);
        end

        // R3: rising edge mode, bypass
        wr(2'd1, 8'h28);
        wr(2'd0, 8'h00);
        ext_to(1'b1); rd(2'd0, v); check("R3 rise counted", v, 1);
        ext_to(1'b0); rd(2'd0, v); check("R3 fall ignored", v, 1);
        pulse(); pulse(); rd(2'd0, v); check("R3 R4 pulses", v, 3);

        // R3: falling edge mode
        wr(2'd1, 8'h38);
        wr(2'd0, 8'h00);
        ext_to(1'b1); rd(2'd0, v); check("R3 rise ignored", v, 0);
        ext_to(1'b0); rd(2'd0, v); check("R3 fall counted", v, 1);

        // R4/R5: external through 1:2 divider
        wr(2'd1, 8'h20);
        wr(2'd0, 8'h00);
        for (int i = 0; i < 5; i++) pulse();
        rd(2'd0, v); check("R4 divided ext", v, 2);

        // R6: count write clears a half-full divider
        wr(2'd0, 8'h00);
        pulse(); rd(2'd0, v); check("R6 after clear one edge", v, 0);
        pulse(); rd(2'd0, v); check("R6 after clear two edges", v, 1);

        // R7: neighbour clear ignored while divider owned
        wr(2'd0, 8'h00);
        pulse();
        @(negedge clk); shared_clr = 1'b1; @(negedge clk); shared_clr = 1'b0;
        pulse(); rd(2'd0, v); check("R7 shared ignored", v, 1);

        // R7: neighbour clear honoured while divider handed over
        wr(2'd0, 8'h00);
        pulse();
        wr(2'd1, 8'h28);
        @(negedge clk); shared_clr = 1'b1; @(negedge clk); shared_clr = 1'b0;
        wr(2'd1, 8'h20);
        pulse(); rd(2'd0, v); check("R7 shared clear", v, 0);
        pulse(); rd(2'd0, v); check("R7 shared clear next", v, 1);

        // R8: a load of 00h after FFh does not set the flag
        wr(2'd1, 8'h28);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'hFF);
        wr(2'd0, 8'h00);
        rd(2'd2, v); check("R8 load no flag", v, 0);

        // R8/R9: overflow by increment
        wr(2'd1, 8'h08);
        wr(2'd2, 8'h02);
        wr(2'd0, 8'hFF);
        idle(4);
        rd(2'd0, v); check("R8 wrap count", v, 0);
        rd(2'd2, v); check("R8 flag set", v, 3);
        check("R9 irq no gie", irq, 0);
        wr(2'd2, 8'h05);
        check("R9 irq no ie", irq, 0);
        wr(2'd2, 8'h07);
        rd(2'd2, v); check("R8 write one keeps", v, 7);
        check("R9 irq on", irq, 1);
        wr(2'd2, 8'h06);
        rd(2'd2, v); check("R8 flag cleared", v, 6);
        check("R9 irq off", irq, 0);

        // R1: read-back after load in a quiet mode
        wr(2'd1, 8'h28);
        wr(2'd0, 8'hA5);
        rd(2'd0, v); check("R1 load", v, 8'hA5);
        rd(2'd1, v); check("R10 cfg readback", v, 8'h28);

        finish_run();
    end
endmodule